// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block sits on the receive side of an Ethernet MAC. It decides, for each incoming frame, whether the frame is kept or dropped, based only on the frame's 48-bit destination address. The receive path feeds it the frame as a byte stream, with a marker on the first byte. The block collects the first six bytes and compares them against three things: one programmed station address, a small table of multicast addresses, and the broadcast address. It then gives a one-cycle decision pulse that carries an accept flag.

Software sets it up through 32-bit configuration writes. The station address takes two writes, a low word and a high word. A multicast entry is written indirectly: a low word is staged first. A high word then carries the top two address bytes and the entry index, and commits the whole entry. Addresses are held with the first byte on the wire in the least significant bits. A promiscuous bit in a mode register accepts every frame. Clearing that bit restores filtering.

Top module: `dst_addr_filter`

## Requirements
- R1: After reset no decision pulse is produced until a frame arrives. The station address and all multicast entries are zero and promiscuous mode is off, so only the broadcast address is accepted.
- R2: The station address is written with two registers. Register 0 holds address bytes 0..3, with byte 0 (first on the wire) in bits 7:0 and byte 3 in bits 31:24. Register 1 holds byte 4 in bits 7:0 and byte 5 in bits 15:8. Bits 31:16 of register 1 have no effect on filtering.
- R3: Register 2 stages bytes 0..3 of a multicast address, in the same layout as R2. A write to register 3 commits the staged word, together with byte 4 in bits 7:0 and byte 5 in bits 15:8, into the table entry selected by bits 17:16. The table has 4 entries.
- R4: An all-zero address, whether it is a table entry or the station address, never matches. A destination of all zero is dropped unless promiscuous mode is on.
- R5: The broadcast destination (all ones) is always accepted.
- R6: Bit 0 of register 4 is the promiscuous bit. While it is 1 every frame is accepted. While it is 0, frames are filtered.
- R7: A decision is produced once per frame. Call k the clock edge that samples the sixth destination byte. The decision valid output is high for exactly one cycle, after edge k+1. The accept output is low whenever valid is low.
- R8: The following produce no decision and do not disturb capture: bytes after the sixth, bytes that arrive without a start-of-frame marker while idle, and idle cycles (valid low) inside the address. A new start-of-frame marker restarts capture at byte 0.
- R9: A write to one table entry leaves the other entries unchanged. Overwriting an entry with zero stops it from matching.
- R10: A destination that differs in any single bit from every programmed address, and is not broadcast, is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 3 | Configuration register select (0..4) |
| cfgWrData | input | 32 | Configuration write data |
| rxValid | input | 1 | Receive byte valid |
| rxFirst | input | 1 | Marks the first byte of a frame |
| rxData | input | 8 | Receive byte |
| decValid | output | 1 | One-cycle decision pulse |
| decAccept | output | 1 | Accept flag, meaningful with decValid |

## Verification
Every bit position of the station address and of each multicast entry is flipped in turn. These destinations must be rejected while the exact address is accepted, which separates a correct full 48-bit compare from a partial or mis-ordered one. A byte-reversed copy of the station address tells the wire-order byte layout apart from its mirror. Zero and broadcast destinations, and zeroed entries, probe the special cases. Frames sent with idle gaps, with trailing bytes and with aborted starts check the capture sequencing. A count of all decision pulses confirms that none appears outside a completed address.

// File: rtl/addr_filter_pkg.sv
package addr_filter_pkg;
  localparam int unsigned MAC_BYTES = 6;
  localparam int unsigned MAC_W     = 8 * MAC_BYTES;
  localparam int unsigned POS_W     = $clog2(MAC_BYTES + 1);
  localparam int unsigned CFG_AW    = 3;

  localparam logic [CFG_AW-1:0] REG_UNI_LO = 3'd0;
  localparam logic [CFG_AW-1:0] REG_UNI_HI = 3'd1;
  localparam logic [CFG_AW-1:0] REG_MC_LO  = 3'd2;
  localparam logic [CFG_AW-1:0] REG_MC_HI  = 3'd3;
  localparam logic [CFG_AW-1:0] REG_MODE   = 3'd4;

  typedef struct packed {
    logic             capture;
    logic [POS_W-1:0] bytePos;
    logic             lastByte;
    logic             wrUniLo;
    logic             wrUniHi;
    logic             wrMcLo;
    logic             wrMcHi;
    logic             wrMode;
  } filtStrobes_t;
endpackage

// File: rtl/addr_filter_ctrl.sv
module addr_filter_ctrl
  import addr_filter_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxValid,
  input  logic              rxFirst,
  input  logic              cfgWrEn,
  input  logic [CFG_AW-1:0] cfgAddr,
  output filtStrobes_t      strb
);
  // posReg: position of the next destination byte; 0 means idle
  logic [POS_W-1:0] posReg;

  always_comb begin
    strb = '0;
    if (rxValid && rxFirst) begin
      strb.capture = 1'b1;
      strb.bytePos = '0;
    end else if (rxValid && posReg != '0) begin
      strb.capture = 1'b1;
      strb.bytePos = posReg;
    end
    strb.lastByte = strb.capture && (strb.bytePos == POS_W'(MAC_BYTES - 1));
    strb.wrUniLo  = cfgWrEn && (cfgAddr == REG_UNI_LO);
    strb.wrUniHi  = cfgWrEn && (cfgAddr == REG_UNI_HI);
    strb.wrMcLo   = cfgWrEn && (cfgAddr == REG_MC_LO);
    strb.wrMcHi   = cfgWrEn && (cfgAddr == REG_MC_HI);
    strb.wrMode   = cfgWrEn && (cfgAddr == REG_MODE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      posReg <= '0;
    end else if (strb.capture) begin
      posReg <= strb.lastByte ? '0 : strb.bytePos + POS_W'(1);
    end
  end
endmodule

// File: rtl/addr_filter_dp.sv
module addr_filter_dp
  import addr_filter_pkg::*;
#(
  parameter int unsigned MC_ENTRIES = 4,
  parameter int unsigned IDX_LSB    = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  filtStrobes_t strb,
  input  logic [31:0]  cfgWrData,
  input  logic [7:0]   rxData,
  output logic         promiscMode,
  output logic         decValid,
  output logic         decAccept
);
  localparam int unsigned IDX_W = (MC_ENTRIES > 1) ? $clog2(MC_ENTRIES) : 1;

  logic [MAC_W-1:0]      uniAddr;
  logic [31:0]           mcStage;
  logic [MAC_W-1:0]      mcTable [MC_ENTRIES];
  logic [MAC_W-1:0]      daReg;
  logic                  pend;
  logic [MC_ENTRIES-1:0] hitVec;
  logic [IDX_W-1:0]      idxSel;
  logic                  uniHit;
  logic                  bcastHit;
  logic                  acceptNow;
  logic                  unusedCfg;

  assign idxSel    = cfgWrData[IDX_LSB +: IDX_W];
  assign unusedCfg = ^cfgWrData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      uniAddr     <= '0;
      mcStage     <= '0;
      promiscMode <= 1'b0;
    end else begin
      if (strb.wrUniLo) uniAddr[31:0]       <= cfgWrData;
      if (strb.wrUniHi) uniAddr[MAC_W-1:32] <= cfgWrData[15:0];
      if (strb.wrMcLo)  mcStage             <= cfgWrData;
      if (strb.wrMode)  promiscMode         <= cfgWrData[0];
    end
  end

  generate
    for (genvar gi = 0; gi < MC_ENTRIES; gi++) begin : g_entry
      always_ff @(posedge clk) begin
        if (!rstN) begin
          mcTable[gi] <= '0;
        end else if (strb.wrMcHi && idxSel == IDX_W'(gi)) begin
          mcTable[gi] <= {cfgWrData[15:0], mcStage};
        end
      end
      assign hitVec[gi] = (mcTable[gi] != '0) && (mcTable[gi] == daReg);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      daReg <= '0;
    end else begin
      for (int b = 0; b < MAC_BYTES; b++) begin
        if (strb.capture && strb.bytePos == POS_W'(b)) daReg[8*b +: 8] <= rxData;
      end
    end
  end

  assign uniHit    = (uniAddr != '0) && (uniAddr == daReg);
  assign bcastHit  = &daReg;
  assign acceptNow = promiscMode | uniHit | bcastHit | (|hitVec);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pend      <= 1'b0;
      decValid  <= 1'b0;
      decAccept <= 1'b0;
    end else begin
      pend      <= strb.lastByte;
      decValid  <= pend;
      decAccept <= pend & acceptNow;
    end
  end
endmodule

// File: rtl/dst_addr_filter.sv
module dst_addr_filter
  import addr_filter_pkg::*;
#(
  parameter int unsigned MC_ENTRIES = 4,
  parameter int unsigned IDX_LSB    = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWrEn,
  input  logic [2:0]  cfgAddr,
  input  logic [31:0] cfgWrData,
  input  logic        rxValid,
  input  logic        rxFirst,
  input  logic [7:0]  rxData,
  output logic        decValid,
  output logic        decAccept
);
  filtStrobes_t strb;
  logic         promiscMode;

  addr_filter_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxFirst(rxFirst),
    .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .strb(strb)
  );

  addr_filter_dp #(.MC_ENTRIES(MC_ENTRIES), .IDX_LSB(IDX_LSB)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgWrData(cfgWrData), .rxData(rxData),
    .promiscMode(promiscMode), .decValid(decValid), .decAccept(decAccept)
  );
endmodule

// File: rtl/dst_addr_filter_chk.sv
module dst_addr_filter_chk
  import addr_filter_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             capture,
  input logic [POS_W-1:0] bytePos,
  input logic             lastByte,
  input logic             promiscMode,
  input logic             decValid,
  input logic             decAccept
);
  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    decValid |=> !decValid);

  assert_quiet_accept_R7: assert property (@(posedge clk) disable iff (!rstN)
    !decValid |-> !decAccept);

  assert_latency_R7: assert property (@(posedge clk) disable iff (!rstN)
    lastByte |=> ##1 decValid);

  assert_promisc_R6: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && $past(promiscMode)) |-> decAccept);

  assert_pos_range_R8: assert property (@(posedge clk) disable iff (!rstN)
    capture |-> (bytePos < POS_W'(MAC_BYTES)));
endmodule

bind dst_addr_filter dst_addr_filter_chk i_chk (
  .clk(clk), .rstN(rstN), .capture(strb.capture), .bytePos(strb.bytePos),
  .lastByte(strb.lastByte), .promiscMode(promiscMode),
  .decValid(decValid), .decAccept(decAccept)
);

// File: tb/test_dst_addr_filter.sv
module test_dst_addr_filter;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [2:0]  cfgAddr = '0;
  logic [31:0] cfgWrData = '0;
  logic        rxValid = 1'b0;
  logic        rxFirst = 1'b0;
  logic [7:0]  rxData = '0;
  logic        decValid;
  logic        decAccept;

  int nChecks = 0;
  int nFails  = 0;
  int pulses  = 0;
  int expPulses = 0;

  logic [47:0] expUni = '0;
  logic [47:0] expMc [4];
  logic [31:0] expStage = '0;
  logic        expPromisc = 1'b0;

  localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;

  always #10 clk = ~clk;

  dst_addr_filter i_dst_addr_filter (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData),
    .rxValid(rxValid), .rxFirst(rxFirst), .rxData(rxData),
    .decValid(decValid), .decAccept(decAccept)
  );

  always @(negedge clk) if (rstN && decValid) pulses++;

  task automatic checkEq(string tag, logic [47:0] act, logic [47:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic expAccept(logic [47:0] da);
    logic r;
    r = expPromisc || (da == BCAST) || (expUni != '0 && da == expUni);
    for (int i = 0; i < 4; i++) if (expMc[i] != '0 && expMc[i] == da) r = 1'b1;
    return r;
  endfunction

  task automatic cfgWrite(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = a; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
    case (a)
      3'd0: expUni[31:0]  = d;
      3'd1: expUni[47:32] = d[15:0];
      3'd2: expStage      = d;
      3'd3: expMc[d[17:16]] = {d[15:0], expStage};
      3'd4: expPromisc    = d[0];
      default: ;
    endcase
  endtask

  task automatic setUni(logic [47:0] a);
    cfgWrite(3'd0, a[31:0]);
    cfgWrite(3'd1, {16'hA5C3, a[47:32]});   // R2: reserved upper bits carry junk
  endtask

  task automatic setMc(int idx, logic [47:0] a);
    cfgWrite(3'd2, a[31:0]);
    cfgWrite(3'd3, {14'h0, 2'(idx), a[47:32]});
  endtask

  task automatic sendDa(logic [47:0] da, string tag, bit gap);
    for (int b = 0; b < 6; b++) begin
      @(negedge clk);
      rxValid = 1'b1; rxFirst = (b == 0); rxData = da[8*b +: 8];
      if (gap && b < 5) begin
        @(negedge clk);
        rxValid = 1'b0; rxFirst = 1'b0; rxData = 8'hFF;
      end
    end
    expPulses++;
    @(negedge clk);
    rxValid = 1'b0; rxFirst = 1'b0;
    checkEq({tag, " R7 early"}, 48'(decValid), 48'd0);
    @(negedge clk);
    checkEq({tag, " R7 valid"}, 48'(decValid), 48'd1);
    checkEq({tag, " accept"}, 48'(decAccept), 48'(expAccept(da)));
    @(negedge clk);
    checkEq({tag, " R7 one-shot"}, 48'(decValid), 48'd0);
  endtask

  task automatic runAll();
    logic [47:0] uni, a;
    for (int i = 0; i < 4; i++) expMc[i] = '0;
    repeat (3) @(negedge clk);
    checkEq("R1 reset valid", 48'(decValid), 48'd0);
    checkEq("R1 reset accept", 48'(decAccept), 48'd0);
    rstN = 1'b1;
    sendDa(48'h0, "R1 R4 zero dest after reset", 0);
    sendDa(BCAST, "R1 R5 broadcast after reset", 0);
    sendDa(48'h0123_4567_89AB, "R1 unicast after reset", 0);

    uni = 48'h6655_4433_2211;
    setUni(uni);
    sendDa(uni, "R2 station match", 0);
    sendDa(48'h1122_3344_5566, "R2 byte reversed", 0);
    for (int bit_i = 0; bit_i < 48; bit_i++)
      sendDa(uni ^ (48'd1 << bit_i), $sformatf("R10 station flip bit %0d", bit_i), 0);

    for (int i = 0; i < 4; i++) setMc(i, 48'hC0FF_EE00_0001 + (48'(i) << 24));
    for (int i = 0; i < 4; i++) begin
      a = 48'hC0FF_EE00_0001 + (48'(i) << 24);
      sendDa(a, $sformatf("R3 entry %0d match", i), 0);
      for (int bit_i = 0; bit_i < 48; bit_i++)
        sendDa(a ^ (48'd1 << bit_i), $sformatf("R10 entry %0d flip bit %0d", i, bit_i), 0);
    end

    setMc(2, 48'h0);
    for (int i = 0; i < 4; i++)
      sendDa(48'hC0FF_EE00_0001 + (48'(i) << 24), $sformatf("R9 after clearing entry 2, entry %0d", i), 0);
    sendDa(48'h0, "R4 zero dest with zero entry", 0);
    sendDa(BCAST, "R5 broadcast with table", 0);

    cfgWrite(3'd4, 32'h1);
    sendDa(48'h0, "R6 promisc zero", 0);
    sendDa(48'h1357_9BDF_0246, "R6 promisc other", 0);
    cfgWrite(3'd4, 32'h0);
    sendDa(48'h1357_9BDF_0246, "R6 promisc cleared", 0);

    sendDa(uni, "R8 station with gaps", 1);
    sendDa(48'h0BAD_0BAD_0BAD, "R8 miss with gaps", 1);
    // R8: trailing bytes after the address give no further decision
    for (int b = 0; b < 8; b++) begin
      @(negedge clk);
      rxValid = 1'b1; rxFirst = 1'b0; rxData = 8'hFF;
      checkEq("R8 trailing bytes", 48'(decValid), 48'd0);
    end
    // R8: an aborted start is replaced by a new start of frame
    for (int b = 0; b < 3; b++) begin
      @(negedge clk);
      rxValid = 1'b1; rxFirst = (b == 0); rxData = 8'hFF;
    end
    sendDa(uni, "R8 restart after abort", 0);
    repeat (4) @(negedge clk);
    checkEq("R8 total decision pulses", 48'(pulses), 48'(expPulses));
  endtask

  initial begin
    runAll();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule